// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block runs the command half of an SD host. Software loads a 32-bit argument and a timeout start value. It then writes the command register with the launch bit set. The engine builds a 48-bit command frame, protects it with CRC7 and shifts it out MSB first on the CMD line, one bit per clock, while driving the output enable. It then does one of three things:

- waits for a 48-bit response, checks its CRC7 and stores it;
- waits for a 136-bit response, checks its CRC7 and stores it;
- skips the response altogether.

When asked, it also holds completion until the card stops pulling DAT0 low.

The command register reports the outcome as well as launching the command. The launch bit reads back as 1 while the command is in flight and drops to 0 by itself when the command ends. A separate fail bit tells software whether the command went wrong. A small write-1-to-clear status register says why it failed, or that a busy wait has ended.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset the command register reads 0, the status register reads 0, `sd_cmd_oe` is 0 and `sd_cmd_out` is 1.
- R2: The register word addresses are: 0 command, 1 argument, 2 timeout start, 3 to 6 response words 0 to 3, 7 status. The command register fields are:
  - bits 5:0 hold the index;
  - bit 6 is the read-data flag and bit 7 is the write-data flag (both are stored only);
  - bit 9 selects a long response, bit 10 selects no response, bit 11 requests a busy wait;
  - bit 14 is fail and bit 15 is launch.

  Writing the command register with bit 15 set, while it is clear, sends the frame {0, 1, index, argument, CRC7 over the first 40 bits with polynomial x^7+x^3+1, 1}. The frame goes out MSB first over 48 consecutive cycles with `sd_cmd_oe` high.
- R3: Bit 15 clears by itself when the command finishes. A no-response command without busy wait finishes on the clock after its last frame bit.
- R4: A write to the command register while bit 15 reads 1 is ignored.
- R5: A short response is 48 bits. Bits 39:8 of the response go to response word 0, and response words 1 to 3 read 0.
- R6: A long response is 136 bits. Its bits 127:0 go to the response words, with word 0 holding bits 31:0 and word 3 holding bits 127:96.
- R7: The timeout counter loads the timeout start value T at launch. If no start bit has arrived after T+1 cycles of waiting, the command finishes with fail set and status bit 0 set.
- R8: If the CRC7 computed over the received bits 47:8 (short response) or 127:8 (long response) differs from received bits 7:1, the command finishes with fail set and status bit 1 set.
- R9: With busy wait requested, the command finishes only once DAT0 reads 1 after the response (or after the frame when no response is expected). It then sets status bit 2.
- R10: A launch with both long response (bit 9) and busy wait (bit 11) sends nothing and finishes at once with fail set and status bit 3 set.
- R11: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R12: A 0 on CMD while the frame is being sent is not taken as a response start bit. Only a 0 that arrives after the frame starts the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one CMD bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| sd_cmd_out | output | 1 | CMD line output value |
| sd_cmd_oe | output | 1 | CMD line output enable |
| sd_cmd_in | input | 1 | CMD line input value |
| sd_dat0_in | input | 1 | DAT0 input, low while the card is busy |

## Verification
The bench targets four mistakes:

- A low level on CMD in the middle of the outgoing frame. A design that listened too early would start capturing its own frame and return a garbage response.
- The exact timeout window. The launch bit must still be set after T+1 waiting cycles. A counter that is off by one, or that was never loaded, ends the command too early or never ends it.
- A busy wait held for many cycles past the response. A design that ignored DAT0 would report completion while the card is still busy.
- A corrupted CRC, a launch while a command is in flight, and the illegal long-plus-busy launch. Each one checks that the fail bit, the status cause and the stored index come out as required, with no frame leaving the block.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int CMD_FRAME_W  = 48;
    localparam int SHORT_RSP_W  = 48;
    localparam int LONG_RSP_W   = 136;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_ARG  = 3'd1;
    localparam logic [2:0] A_TMO  = 3'd2;
    localparam logic [2:0] A_RSP0 = 3'd3;
    localparam logic [2:0] A_STS  = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_CHECK, ST_BUSY
    } state_e;

    // CRC7, polynomial x^7 + x^3 + 1, over the low nbits of bits, MSB first
    function automatic logic [6:0] crc7_calc(input logic [119:0] bits, input int nbits);
        logic [6:0] c;
        logic fb;
        c = 7'd0;
        for (int i = 0; i < 120; i++) begin
            if (i < nbits) begin
                fb = bits[nbits-1-i] ^ c[6];
                c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift,
    output logic               bit_o
);
    logic [FRAME_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)       sr_d = frame_i;
        else if (shift) sr_d = {sr_q[FRAME_W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign bit_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx #(
    parameter int FRAME_W = 136
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [FRAME_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clear)      sr_d = {{(FRAME_W-1){1'b0}}, bit_i};
        else if (shift) sr_d = {sr_q[FRAME_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign frame_o = sr_q;
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        sd_cmd_out,
    output logic        sd_cmd_oe,
    input  logic        sd_cmd_in,
    input  logic        sd_dat0_in
);
    localparam int CNT_W = $clog2(LONG_RSP_W + 1);

    typedef struct packed {
        state_e             state;
        logic [5:0]         idx;
        logic               rd_f;
        logic               wr_f;
        logic               long_f;
        logic               nors_f;
        logic               busy_f;
        logic               new_f;
        logic               fail_f;
        logic [31:0]        arg;
        logic [TMO_W-1:0]   tmo_start;
        logic [TMO_W-1:0]   tmo_cnt;
        logic [CNT_W-1:0]   bitcnt;
        logic [3:0][31:0]   rsp;
        logic [3:0]         sts;
    } regs_t;

    regs_t q, d;

    logic                    tx_load, tx_shift, tx_bit;
    logic                    rx_clear, rx_shift;
    logic [CMD_FRAME_W-1:0]  tx_frame;
    logic [LONG_RSP_W-1:0]   rx_frame;
    logic [39:0]             hdr;
    logic [6:0]              rx_crc;
    logic                    launch_ok;

    sdc_cmd_tx #(.FRAME_W(CMD_FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .frame_i(tx_frame),
        .shift(tx_shift), .bit_o(tx_bit)
    );

    sdc_rsp_rx #(.FRAME_W(LONG_RSP_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear), .shift(rx_shift),
        .bit_i(sd_cmd_in), .frame_o(rx_frame)
    );

    assign hdr      = {2'b01, reg_wdata[5:0], q.arg};
    assign tx_frame = {hdr, crc7_calc({80'd0, hdr}, 40), 1'b1};
    assign rx_crc   = q.long_f ? crc7_calc(rx_frame[127:8], 120)
                               : crc7_calc({80'd0, rx_frame[47:8]}, 40);
    assign launch_ok = reg_wr && (reg_addr == A_CMD) && !q.new_f;

    always_comb begin
        d        = q;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        rx_clear = 1'b0;
        rx_shift = 1'b0;

        // register writes (status clears first so engine sets win)
        if (reg_wr) begin
            unique case (reg_addr)
                A_CMD: if (!q.new_f) begin
                    d.idx    = reg_wdata[5:0];
                    d.rd_f   = reg_wdata[6];
                    d.wr_f   = reg_wdata[7];
                    d.long_f = reg_wdata[9];
                    d.nors_f = reg_wdata[10];
                    d.busy_f = reg_wdata[11];
                    if (reg_wdata[15]) begin
                        if (reg_wdata[9] && reg_wdata[11]) begin
                            d.fail_f = 1'b1;
                            d.sts[3] = 1'b1;
                        end else begin
                            d.new_f   = 1'b1;
                            d.fail_f  = 1'b0;
                            d.state   = ST_SEND;
                            d.bitcnt  = '0;
                            d.tmo_cnt = q.tmo_start;
                            tx_load   = 1'b1;
                        end
                    end
                end
                A_ARG: d.arg = reg_wdata;
                A_TMO: d.tmo_start = reg_wdata[TMO_W-1:0];
                A_STS: d.sts = q.sts & ~reg_wdata[3:0];
                default: ;
            endcase
        end

        unique case (q.state)
            ST_SEND: begin
                tx_shift = 1'b1;
                d.bitcnt = q.bitcnt + 1'b1;
                if (q.bitcnt == CNT_W'(CMD_FRAME_W - 1)) begin
                    if (!q.nors_f)     d.state = ST_WAIT;
                    else if (q.busy_f) d.state = ST_BUSY;
                    else begin
                        d.state = ST_IDLE;
                        d.new_f = 1'b0;
                    end
                end
            end
            ST_WAIT: begin
                if (!sd_cmd_in) begin
                    rx_clear = 1'b1;
                    d.bitcnt = CNT_W'(1);
                    d.state  = ST_RECV;
                end else if (q.tmo_cnt == '0) begin
                    d.fail_f = 1'b1;
                    d.sts[0] = 1'b1;
                    d.new_f  = 1'b0;
                    d.state  = ST_IDLE;
                end else begin
                    d.tmo_cnt = q.tmo_cnt - 1'b1;
                end
            end
            ST_RECV: begin
                rx_shift = 1'b1;
                d.bitcnt = q.bitcnt + 1'b1;
                if (q.bitcnt == (q.long_f ? CNT_W'(LONG_RSP_W - 1) : CNT_W'(SHORT_RSP_W - 1)))
                    d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (q.long_f) d.rsp = rx_frame[127:0];
                else          d.rsp = {96'd0, rx_frame[39:8]};
                if (rx_crc != rx_frame[7:1]) begin
                    d.fail_f = 1'b1;
                    d.sts[1] = 1'b1;
                    d.new_f  = 1'b0;
                    d.state  = ST_IDLE;
                end else if (q.busy_f) begin
                    d.state = ST_BUSY;
                end else begin
                    d.new_f = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (sd_dat0_in) begin
                    d.sts[2] = 1'b1;
                    d.new_f  = 1'b0;
                    d.state  = ST_IDLE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sd_cmd_oe  = (q.state == ST_SEND);
    assign sd_cmd_out = sd_cmd_oe ? tx_bit : 1'b1;

    always_comb begin
        unique case (reg_raddr)
            A_CMD:   reg_rdata = {16'd0, q.new_f, q.fail_f, 2'b00, q.busy_f, q.nors_f,
                                  q.long_f, 1'b0, q.wr_f, q.rd_f, q.idx};
            A_ARG:   reg_rdata = q.arg;
            A_TMO:   reg_rdata = 32'(q.tmo_start);
            A_STS:   reg_rdata = {28'd0, q.sts};
            default: reg_rdata = q.rsp[reg_raddr - A_RSP0];
        endcase
    end

    AST_OE_ONLY_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd_oe |-> q.new_f); // R2
    AST_LAUNCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && q.new_f) |=> $stable(q.idx)); // R4
    AST_TMO_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sts[0]) |-> (q.fail_f && !q.new_f)); // R7
    AST_CRC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sts[1]) |-> (q.fail_f && !q.new_f)); // R8
    AST_BUSY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sts[2]) |-> $past(sd_dat0_in)); // R9
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_ok && reg_wdata[15] && reg_wdata[9] && reg_wdata[11])
        |=> (!sd_cmd_oe && q.fail_f && !q.new_f)); // R10
endmodule

// File: tb/sim_sdc_cmd_engine.sv
module sim_sdc_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        sd_cmd_out, sd_cmd_oe;
    logic        sd_cmd_in = 1'b1;
    logic        sd_dat0_in = 1'b1;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sdc_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .sd_cmd_out(sd_cmd_out), .sd_cmd_oe(sd_cmd_oe), .sd_cmd_in(sd_cmd_in),
        .sd_dat0_in(sd_dat0_in)
    );

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n);
        logic [6:0] c = 7'd0;
        for (int i = n - 1; i >= 0; i--) begin
            logic t = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (t) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    // issue a launch; returns at the negedge after the write
    task automatic launch(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // collect 48 frame bits; optionally drive a 0 on CMD mid-frame
    task automatic capture(output logic [47:0] f, input bit glitch);
        int guard = 0;
        while (!sd_cmd_oe && guard < 10) begin
            @(negedge clk); guard++;
        end
        f = '0;
        for (int i = 0; i < 48; i++) begin
            if (glitch && i == 5)  sd_cmd_in = 1'b0;
            if (glitch && i == 30) sd_cmd_in = 1'b1;
            f = {f[46:0], (sd_cmd_oe ? sd_cmd_out : 1'bx)};
            if (i != 47) @(negedge clk);
        end
    endtask

    task automatic send_rsp(input logic [135:0] bits, input int n, input int gap);
        repeat (gap) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sd_cmd_in = bits[i];
            @(negedge clk);
        end
        sd_cmd_in = 1'b1;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        int n = 0;
        rd(3'd0, v);
        while (v[15] && n < 2000) begin
            @(negedge clk); rd(3'd0, v); n++;
        end
        chk({tag, " launch bit cleared"}, {31'd0, v[15]}, 32'd0);
    endtask

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h = {2'b01, idx, arg};
        return {h, ref_crc({96'd0, h}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] dat, input bit bad);
        logic [39:0] h = {2'b00, idx, dat};
        logic [6:0] c = ref_crc({96'd0, h}, 40) ^ (bad ? 7'h01 : 7'h00);
        return {88'd0, h, c, 1'b1};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 command reg after reset", v, 32'd0);
        rd(3'd7, v); chk("R1 status after reset", v, 32'd0);
        chk("R1 oe/out after reset", {30'd0, sd_cmd_oe, sd_cmd_out}, 32'd1);
    endtask

    task automatic t_norsp();
        logic [47:0] f;
        logic [31:0] v;
        wr(3'd1, 32'h0000_0000);
        launch(32'h0000_8400);
        capture(f, 0);
        chk("R2 no-resp frame hi", {16'd0, f[47:32]}, {16'd0, exp_frame(6'd0, 32'd0) >> 32});
        chk("R2 no-resp frame lo", f[31:0], exp_frame(6'd0, 32'd0) & 48'hFFFF_FFFF);
        @(negedge clk);
        rd(3'd0, v);
        chk("R3 no-resp done one clock after frame", {16'd0, v[15:0]}, 32'h0000_0400);
    endtask

    task automatic t_short(input bit glitch);
        logic [47:0] f;
        logic [31:0] v;
        logic [47:0] e = exp_frame(6'd17, 32'hDEAD_BEEF);
        wr(3'd2, 32'd200);
        wr(3'd1, 32'hDEAD_BEEF);
        launch(32'h0000_8051);
        capture(f, glitch);
        chk("R2 short frame hi", {16'd0, f[47:32]}, {16'd0, e[47:32]});
        chk("R2 short frame lo", f[31:0], e[31:0]);
        if (!glitch) begin
            wr(3'd0, 32'h0000_8005);
            rd(3'd0, v);
            chk("R4 write during flight ignored", {16'd0, v[15:0]}, 32'h0000_8051);
        end
        send_rsp(short_rsp(6'd17, 32'h0000_0920, 0), 48, 3);
        wait_done("R5 short");
        rd(3'd0, v); chk(glitch ? "R12 no fail after mid-frame low" : "R5 no fail", v, 32'h0000_0051);
        rd(3'd3, v); chk(glitch ? "R12 response word0" : "R5 response word0", v, 32'h0000_0920);
        rd(3'd4, v); chk("R5 response word1 zero", v, 32'd0);
        rd(3'd6, v); chk("R5 response word3 zero", v, 32'd0);
    endtask

    task automatic t_long();
        logic [47:0] f;
        logic [31:0] v;
        logic [119:0] p = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
        logic [135:0] r;
        r = {2'b00, 6'h3F, p, ref_crc({16'd0, p}, 120), 1'b1};
        wr(3'd1, 32'h1234_0000);
        launch(32'h0000_8202);
        capture(f, 0);
        send_rsp(r, 136, 4);
        wait_done("R6 long");
        rd(3'd0, v); chk("R6 long no fail", {16'd0, v[15:14], 14'd0}, 32'd0);
        rd(3'd3, v); chk("R6 long word0", v, r[31:0]);
        rd(3'd4, v); chk("R6 long word1", v, r[63:32]);
        rd(3'd5, v); chk("R6 long word2", v, r[95:64]);
        rd(3'd6, v); chk("R6 long word3", v, r[127:96]);
    endtask

    task automatic t_timeout();
        logic [47:0] f;
        logic [31:0] v;
        wr(3'd2, 32'd20);
        launch(32'h0000_8008);
        capture(f, 0);
        repeat (21) @(negedge clk);
        rd(3'd0, v); chk("R7 still waiting inside window", {31'd0, v[15]}, 32'd1);
        wait_done("R7 timeout");
        rd(3'd0, v); chk("R7 fail after timeout", {31'd0, v[14]}, 32'd1);
        rd(3'd7, v); chk("R7 timeout status bit0", v, 32'h1);
        wr(3'd7, 32'h0);
        rd(3'd7, v); chk("R11 zero write keeps status", v, 32'h1);
        wr(3'd7, 32'h1);
        rd(3'd7, v); chk("R11 one write clears status", v, 32'h0);
    endtask

    task automatic t_crc();
        logic [47:0] f;
        logic [31:0] v;
        wr(3'd2, 32'd200);
        launch(32'h0000_800D);
        capture(f, 0);
        send_rsp(short_rsp(6'd13, 32'hCAFE_0001, 1), 48, 2);
        wait_done("R8 crc");
        rd(3'd0, v); chk("R8 fail on bad crc", {31'd0, v[14]}, 32'd1);
        rd(3'd7, v); chk("R8 crc status bit1", v, 32'h2);
        wr(3'd7, 32'hF);
    endtask

    task automatic t_busy();
        logic [47:0] f;
        logic [31:0] v;
        launch(32'h0000_8807);
        capture(f, 0);
        sd_dat0_in = 1'b0;
        send_rsp(short_rsp(6'd7, 32'h0000_0700, 0), 48, 2);
        repeat (30) @(negedge clk);
        rd(3'd0, v); chk("R9 held while DAT0 low", {31'd0, v[15]}, 32'd1);
        sd_dat0_in = 1'b1;
        wait_done("R9 busy");
        rd(3'd0, v); chk("R9 no fail", {31'd0, v[14]}, 32'd0);
        rd(3'd7, v); chk("R9 busy status bit2", v, 32'h4);
        wr(3'd7, 32'h4);
    endtask

    task automatic t_reject();
        logic [31:0] v;
        bit seen = 0;
        launch(32'h0000_8A02);
        for (int i = 0; i < 10; i++) begin
            if (sd_cmd_oe) seen = 1;
            @(negedge clk);
        end
        chk("R10 nothing sent", {31'd0, seen}, 32'd0);
        rd(3'd0, v); chk("R10 launch clear, fail set", {16'd0, v[15:14], 14'd0}, 32'h0000_4000);
        rd(3'd7, v); chk("R10 reject status bit3", v, 32'h8);
        wr(3'd7, 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_norsp();
        t_short(0);
        t_short(1);
        t_long();
        t_timeout();
        t_crc();
        t_busy();
        t_reject();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end
endmodule